// File: doc/BRIEF.md
# Two-Level JTAG Test Access Port with Switchable Core Link

This block is the test access port a chip presents on its external JTAG pins. After a test reset, the chain holds only one TAP, the top-level TAP. A second TAP, the core TAP, stays parked in Test-Logic-Reset and its pins are cut off from the chain. A host splices the core TAP in with two scans. The first loads the link instruction into the top-level TAP. The second shifts a 64-bit link word whose least significant bit requests the core TAP.

The top-level TAP latches the new link word on Update-DR. The chain topology changes only when the top-level controller is next in Run-Test/Idle, so a scan already in flight keeps its length. Once the core is linked, it sits nearest TDI. Its serial output drives the top-level TAP's serial input, and the top-level TAP drives the pin. Both TAPs have an 8-bit instruction register and their own IDCODE and BYPASS registers.

Top module: `tap_chain_link`

## Requirements
- R1: While trst_n is low, and for two rising TCK edges after it rises, both controllers are in Test-Logic-Reset. The tdo_oe output is 0 during this time and the core TAP is unlinked.
- R2: Each instruction register is 8 bits wide. On Capture-IR it loads 0x01, so bit 0 is 1 and bits 7:1 are 0. Bit 0 leaves first.
- R3: In Test-Logic-Reset, the top-level TAP's instruction becomes IDCODE (0x01). A data scan then shifts out 0x0E681013, least significant bit first.
- R4: Opcode 0xFF selects a 1-bit BYPASS register, which captures 0.
- R5: Top-level opcode 0x11 selects a 64-bit link register. It captures its current value, which shifts out LSB first. A new value is latched on Update-DR, and that value is the last 64 bits shifted in.
- R6: When link bit 0 is 1, the core TAP sits between tdi and the top-level TAP. The chain is then core first, top-level TAP last toward tdo.
- R7: A changed link bit takes effect only at a rising TCK edge where the top-level controller is in Run-Test/Idle. A scan that starts without passing Run-Test/Idle still sees the old topology.
- R8: Once linked, the core TAP's IDCODE is 0x18289013.
- R9: Writing a link word with bit 0 at 0 removes the core TAP. The chain then holds the top-level TAP alone.
- R10: Asserting trst_n asynchronously forces tdo_oe low and clears the link register, which unlinks the core TAP.
- R11: tdo changes only on falling TCK edges. tdo_oe is 1 exactly when the top-level controller is in Shift-IR or Shift-DR.
- R12: An unassigned opcode, for example 0x5A, selects BYPASS.
- R13: While unlinked, the core controller is held in Test-Logic-Reset, with its TMS forced high. On relinking, its instruction is therefore IDCODE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, asynchronous assertion |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for tdo; high only while shifting |

## Verification
TMS and TDI are sampled on a rising edge, and a shift result appears on tdo at the falling edge that follows. The bench therefore updates its behavioural model right after each rising edge. It compares tdo and tdo_oe one time unit after the next falling edge, on every cycle.

A link change appears one rising edge after the top-level controller is seen in Run-Test/Idle. Topology is checked on scans that either skip Run-Test/Idle or follow the host's ten idle cycles. Reset release is delayed by two rising edges in the model to match the synchronous release.

// File: rtl/tapln_pkg.sv
package tapln_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SCAN, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SCAN, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_state_e;

  typedef enum logic [1:0] {DRK_BYP, DRK_ID, DRK_LINK} dr_kind_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    case (s)
      ST_RESET:    n = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     n = tms ? ST_DR_SCAN  : ST_IDLE;
      ST_DR_SCAN:  n = tms ? ST_IR_SCAN  : ST_DR_CAP;
      ST_DR_CAP:   n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: n = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: n = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: n = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   n = tms ? ST_DR_SCAN  : ST_IDLE;
      ST_IR_SCAN:  n = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: n = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: n = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: n = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      default:     n = tms ? ST_DR_SCAN  : ST_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tapln_fsm.sv
module tapln_fsm
  import tapln_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = hold ? ST_RESET : tap_next(state, tms);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_d;
  end

endmodule

// File: rtl/tapln_tap.sv
module tapln_tap
  import tapln_pkg::*;
#(
  parameter int              IR_W    = 8,
  parameter logic [31:0]     ID_VAL  = 32'h0000_0001,
  parameter logic [IR_W-1:0] ID_OP   = {{(IR_W-1){1'b0}}, 1'b1},
  parameter logic [IR_W-1:0] BYP_OP  = {IR_W{1'b1}},
  parameter bit              HAS_LNK = 1'b0,
  parameter logic [IR_W-1:0] LNK_OP  = {IR_W{1'b0}},
  parameter int              LNK_W   = 64
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdo_en,
  output logic       link_bit,
  output tap_state_e state
);

  localparam int              ID_W   = 32;
  localparam logic [IR_W-1:0] IR_CAP = {{(IR_W-2){1'b0}}, 2'b01};

  tapln_fsm u_fsm (
    .tck  (tck),
    .rst_n(rst_n),
    .hold (hold),
    .tms  (tms),
    .state(state)
  );

  logic is_cap_dr, is_sh_dr, shifting;
  assign is_cap_dr = (state == ST_DR_CAP);
  assign is_sh_dr  = (state == ST_DR_SHIFT);
  assign shifting  = is_sh_dr || (state == ST_IR_SHIFT);

  // Instruction path
  logic [IR_W-1:0] irsh_q, irsh_d, ir_q, ir_d;
  logic            irsh_en, ir_en;

  always_comb begin
    irsh_en = (state == ST_IR_CAP) || (state == ST_IR_SHIFT);
    irsh_d  = (state == ST_IR_CAP) ? IR_CAP : {tdi, irsh_q[IR_W-1:1]};
    ir_en   = (state == ST_IR_UPD) || (state == ST_RESET);
    ir_d    = (state == ST_RESET) ? ID_OP : irsh_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      irsh_q <= IR_CAP;
      ir_q   <= ID_OP;
    end else begin
      if (irsh_en) irsh_q <= irsh_d;
      if (ir_en)   ir_q   <= ir_d;
    end
  end

  assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_IR_CAP) |=> (irsh_q[1:0] == 2'b01));

  assert_reset_loads_id_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |=> (ir_q == ID_OP));

  // Data register decode; unassigned opcodes fall to bypass
  dr_kind_e kind;
  always_comb begin
    if (ir_q == ID_OP)                  kind = DRK_ID;
    else if (HAS_LNK && ir_q == LNK_OP) kind = DRK_LINK;
    else                                kind = DRK_BYP;
  end

  logic [ID_W-1:0] idsh_q, idsh_d;
  logic            idsh_en, byp_q, byp_d, byp_en;

  always_comb begin
    idsh_en = (kind == DRK_ID) && (is_cap_dr || is_sh_dr);
    idsh_d  = is_cap_dr ? ID_VAL : {tdi, idsh_q[ID_W-1:1]};
    byp_en  = (kind == DRK_BYP) && (is_cap_dr || is_sh_dr);
    byp_d   = is_cap_dr ? 1'b0 : tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      idsh_q <= '0;
      byp_q  <= 1'b0;
    end else begin
      if (idsh_en) idsh_q <= idsh_d;
      if (byp_en)  byp_q  <= byp_d;
    end
  end

  logic lnk_lsb;

  generate
    if (HAS_LNK) begin : g_link
      logic [LNK_W-1:0] lsh_q, lsh_d, lnk_q;
      logic             lsh_en, lnk_en;

      always_comb begin
        lsh_en = (kind == DRK_LINK) && (is_cap_dr || is_sh_dr);
        lsh_d  = is_cap_dr ? lnk_q : {tdi, lsh_q[LNK_W-1:1]};
        lnk_en = (kind == DRK_LINK) && (state == ST_DR_UPD);
      end

      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
          lsh_q <= '0;
          lnk_q <= '0;
        end else begin
          if (lsh_en) lsh_q <= lsh_d;
          if (lnk_en) lnk_q <= lsh_q;
        end
      end

      assign lnk_lsb  = lsh_q[0];
      assign link_bit = lnk_q[0];
    end else begin : g_nolink
      assign lnk_lsb  = 1'b0;
      assign link_bit = 1'b0;
    end
  endgenerate

  // Serial output, retimed to the falling edge
  logic so;
  always_comb begin
    if (state == ST_IR_SHIFT) so = irsh_q[0];
    else begin
      case (kind)
        DRK_ID:   so = idsh_q[0];
        DRK_LINK: so = lnk_lsb;
        default:  so = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= shifting;
      if (shifting) tdo <= so;
    end
  end

  assert_oe_only_shift_R11: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));

endmodule

// File: rtl/tap_chain_link.sv
module tap_chain_link
  import tapln_pkg::*;
#(
  parameter int              IR_W    = 8,
  parameter logic [31:0]     TOP_ID  = 32'h0E68_1013,
  parameter logic [31:0]     CORE_ID = 32'h1828_9013,
  parameter logic [IR_W-1:0] LNK_OP  = 8'h11,
  parameter int              LNK_W   = 64
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe
);

  localparam logic [IR_W-1:0] ID_OP  = {{(IR_W-1){1'b0}}, 1'b1};
  localparam logic [IR_W-1:0] BYP_OP = {IR_W{1'b1}};

  // Asynchronous assertion, release aligned to rising TCK
  logic [1:0] rst_q;
  logic       rst_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  tap_state_e top_state, core_state;
  logic       top_link, linked, link_en, link_d;
  logic       core_tms, core_tdo, top_tdi;
  logic       core_oe_unused, core_link_unused;

  always_comb begin
    link_en  = (top_state == ST_IDLE);
    link_d   = top_link;
    core_tms = linked ? tms : 1'b1;
    top_tdi  = linked ? core_tdo : tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       linked <= 1'b0;
    else if (link_en) linked <= link_d;
  end

  tapln_tap #(
    .IR_W(IR_W), .ID_VAL(CORE_ID), .ID_OP(ID_OP), .BYP_OP(BYP_OP),
    .HAS_LNK(1'b0), .LNK_OP(LNK_OP), .LNK_W(LNK_W)
  ) u_core (
    .tck     (tck),
    .rst_n   (rst_n),
    .hold    (!linked),
    .tms     (core_tms),
    .tdi     (tdi),
    .tdo     (core_tdo),
    .tdo_en  (core_oe_unused),
    .link_bit(core_link_unused),
    .state   (core_state)
  );

  tapln_tap #(
    .IR_W(IR_W), .ID_VAL(TOP_ID), .ID_OP(ID_OP), .BYP_OP(BYP_OP),
    .HAS_LNK(1'b1), .LNK_OP(LNK_OP), .LNK_W(LNK_W)
  ) u_top (
    .tck     (tck),
    .rst_n   (rst_n),
    .hold    (1'b0),
    .tms     (tms),
    .tdi     (top_tdi),
    .tdo     (tdo),
    .tdo_en  (tdo_oe),
    .link_bit(top_link),
    .state   (top_state)
  );

  assert_link_moves_in_idle_R7: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(linked) |-> ($past(top_state) == ST_IDLE));

  assert_core_parked_R13: assert property (@(posedge tck) disable iff (!rst_n)
    (!linked && $past(!linked)) |-> (core_state == ST_RESET));

endmodule

// File: tb/tap_chain_link_tb_top.sv
module tap_chain_link_tb_top;

  localparam int          CLK_PERIOD = 20;
  localparam logic [31:0] TOP_ID     = 32'h0E68_1013;
  localparam logic [31:0] CORE_ID    = 32'h1828_9013;

  localparam int S_TLR = 0, S_RTI = 1, S_SDS = 2, S_CDR = 3, S_SDR = 4, S_E1D = 5,
                 S_PD = 6, S_E2D = 7, S_UDR = 8, S_SIS = 9, S_CIR = 10, S_SIR = 11,
                 S_E1I = 12, S_PI = 13, S_E2I = 14, S_UIR = 15;

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic tdo, tdo_oe;

  tap_chain_link dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  initial forever #(CLK_PERIOD/2) tck = ~tck;

  int n_cmp = 0;
  int n_bad = 0;

  // Behavioural reference model
  int          m_top, m_core, m_rst_hold;
  logic [7:0]  m_top_ir, m_core_ir;
  logic [63:0] m_sel;
  bit          m_link;
  bit          q_top[$];
  bit          q_core[$];

  function automatic int nxt(input int s, input bit t);
    case (s)
      S_TLR: return t ? S_TLR : S_RTI;
      S_RTI: return t ? S_SDS : S_RTI;
      S_SDS: return t ? S_SIS : S_CDR;
      S_CDR: return t ? S_E1D : S_SDR;
      S_SDR: return t ? S_E1D : S_SDR;
      S_E1D: return t ? S_UDR : S_PD;
      S_PD:  return t ? S_E2D : S_PD;
      S_E2D: return t ? S_UDR : S_SDR;
      S_UDR: return t ? S_SDS : S_RTI;
      S_SIS: return t ? S_TLR : S_CIR;
      S_CIR: return t ? S_E1I : S_SIR;
      S_SIR: return t ? S_E1I : S_SIR;
      S_E1I: return t ? S_UIR : S_PI;
      S_PI:  return t ? S_E2I : S_PI;
      S_E2I: return t ? S_UIR : S_SIR;
      default: return t ? S_SDS : S_RTI;
    endcase
  endfunction

  task automatic model_reset();
    m_top = S_TLR; m_core = S_TLR;
    m_top_ir = 8'h01; m_core_ir = 8'h01;
    m_sel = '0; m_link = 1'b0;
    q_top.delete(); q_core.delete();
  endtask

  task automatic tap_step(inout int st, inout logic [7:0] ir, ref bit q[$],
                          input bit t, input bit din, input bit is_top, input logic [31:0] idv);
    case (st)
      S_TLR: ir = 8'h01;
      S_CIR: begin
        q.delete(); q.push_back(1'b1);
        for (int i = 1; i < 8; i++) q.push_back(1'b0);
      end
      S_SIR, S_SDR: begin
        if (q.size() > 0) void'(q.pop_front());
        q.push_back(din);
      end
      S_UIR: if (q.size() == 8) for (int i = 0; i < 8; i++) ir[i] = q[i];
      S_CDR: begin
        q.delete();
        if (ir == 8'h01)                for (int i = 0; i < 32; i++) q.push_back(idv[i]);
        else if (is_top && ir == 8'h11) for (int i = 0; i < 64; i++) q.push_back(m_sel[i]);
        else                            q.push_back(1'b0);
      end
      S_UDR: if (is_top && ir == 8'h11 && q.size() == 64)
               for (int i = 0; i < 64; i++) m_sel[i] = q[i];
      default: ;
    endcase
    st = nxt(st, t);
  endtask

  task automatic model_rise();
    bit core_out, top_in, old_link;
    int top_pre;
    if (!trst_n || m_rst_hold > 0) begin
      model_reset();
      if (!trst_n) m_rst_hold = 2;
      else         m_rst_hold--;
      return;
    end
    core_out = (q_core.size() > 0) ? q_core[0] : 1'b0;
    top_in   = m_link ? core_out : tdi;
    old_link = m_link;
    top_pre  = m_top;
    if (old_link) tap_step(m_core, m_core_ir, q_core, tms, tdi, 1'b0, CORE_ID);
    else begin
      if (m_core == S_TLR) m_core_ir = 8'h01;
      m_core = S_TLR;
    end
    tap_step(m_top, m_top_ir, q_top, tms, top_in, 1'b1, TOP_ID);
    if (top_pre == S_RTI) m_link = m_sel[0];
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-cycle compare of the pins against the model (R11 and chain contents)
  task automatic compare_pins();
    bit exp_en;
    exp_en = (m_top == S_SIR) || (m_top == S_SDR);
    chk("R11 tdo_oe", {127'b0, tdo_oe}, {127'b0, exp_en});
    if (exp_en) chk("R6 tdo", {127'b0, tdo}, {127'b0, q_top[0]});
  endtask

  task automatic tick(input bit t, input bit d);
    tms = t; tdi = d;
    @(posedge tck);
    model_rise();
    @(negedge tck);
    #1;
    compare_pins();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic scan(input bit ir, input int n, input logic [127:0] d,
                      input bit from_rti, input bit end_rti, output logic [127:0] q);
    q = '0;
    if (from_rti) tick(1'b1, 1'b0);
    if (ir)       tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      q[i] = tdo;
      tick(i == n - 1, d[i]);
    end
    tick(1'b1, 1'b0);
    tick(!end_rti, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] r;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    m_rst_hold = 2;
    model_reset();
    @(negedge tck); #1;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    trst_n = 1'b1;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    chk("R1 oe after reset", {127'b0, tdo_oe}, '0);
    tick(1'b0, 1'b0);

    // R3: IDCODE selected from reset
    scan(1'b0, 32, '0, 1'b1, 1'b1, r);
    chk("R3 top idcode", r[31:0], {96'b0, TOP_ID});

    // R2 capture pattern, R12 unknown opcode
    scan(1'b1, 8, 128'h5A, 1'b1, 1'b1, r);
    chk("R2 ir capture", r[7:0], 128'h01);
    scan(1'b0, 3, 128'b011, 1'b1, 1'b1, r);
    chk("R12 unknown opcode bypass", r[2:0], 128'b110);

    // R4 bypass
    scan(1'b1, 8, 128'hFF, 1'b1, 1'b1, r);
    scan(1'b0, 3, 128'b011, 1'b1, 1'b1, r);
    chk("R4 bypass", r[2:0], 128'b110);

    // R5 link register, R7 deferred topology change
    scan(1'b1, 8, 128'h11, 1'b1, 1'b1, r);
    scan(1'b0, 64, '0, 1'b1, 1'b1, r);
    chk("R5 link reset value", r[63:0], '0);
    scan(1'b0, 65, 128'h3, 1'b1, 1'b0, r);
    chk("R5 link length", {127'b0, r[64]}, 128'h1);
    scan(1'b0, 65, 128'h3, 1'b0, 1'b1, r);
    chk("R5 link readback", r[63:0], 128'h1);
    chk("R7 no switch before idle", {127'b0, r[64]}, 128'h1);
    idle(10);

    // R6 chain order, R8 core idcode
    scan(1'b1, 16, 128'h0101, 1'b1, 1'b1, r);
    chk("R6 linked ir capture", r[15:0], 128'h0101);
    scan(1'b0, 64, '0, 1'b1, 1'b1, r);
    chk("R6 top idcode nearest tdo", r[31:0], {96'b0, TOP_ID});
    chk("R8 core idcode", r[63:32], {96'b0, CORE_ID});
    scan(1'b1, 16, 128'hFFFF, 1'b1, 1'b1, r);
    scan(1'b0, 4, 128'b0011, 1'b1, 1'b1, r);
    chk("R4 two bypass bits", r[3:0], 128'b1100);

    // R9 unlink
    scan(1'b1, 16, 128'hFF11, 1'b1, 1'b1, r);
    scan(1'b0, 65, '0, 1'b1, 1'b1, r);
    chk("R5 linked readback", r[64:0], 128'h1);
    idle(10);
    scan(1'b1, 8, 128'h01, 1'b1, 1'b1, r);
    scan(1'b0, 33, '0, 1'b1, 1'b1, r);
    chk("R9 single tap idcode", r[32:0], {95'b0, 1'b0, TOP_ID});

    // R13 core parked, IDCODE after relink
    scan(1'b1, 8, 128'h11, 1'b1, 1'b1, r);
    scan(1'b0, 64, 128'h1, 1'b1, 1'b1, r);
    idle(10);
    scan(1'b0, 96, 128'h1, 1'b1, 1'b1, r);
    chk("R13 link kept", r[63:0], 128'h1);
    chk("R13 core idcode after park", r[95:64], {96'b0, CORE_ID});

    // R10 asynchronous reset in mid-scan
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    chk("R11 oe while shifting", {127'b0, tdo_oe}, 128'h1);
    trst_n = 1'b0;
    #1;
    chk("R10 oe drops at once", {127'b0, tdo_oe}, '0);
    model_reset();
    m_rst_hold = 2;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    trst_n = 1'b1;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    scan(1'b0, 33, '0, 1'b1, 1'b1, r);
    chk("R10 core unlinked", r[32:0], {95'b0, 1'b0, TOP_ID});
    scan(1'b1, 8, 128'h11, 1'b1, 1'b1, r);
    scan(1'b0, 64, '0, 1'b1, 1'b1, r);
    chk("R10 link cleared", r[63:0], '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule